// File: doc/BRIEF.md
# Ring-Oscillator Speed Monitor Channel

This block estimates silicon speed by counting the edges of one on-die ring oscillator during a window whose length is a programmed number of reference-clock cycles. Software picks a ring through a select field, programs the window length, enables the channel and then starts it. When the window has closed and the count has settled, a done flag appears in the status word and the edge count can be read. Clearing start returns the channel to idle and discards the old result.

Three clock domains meet here. The bus side holds the registers. The reference side (nominally 24 MHz, so a window of T microseconds is programmed as T×24) times the window. The selected ring clock drives the edge counter. The window-active level crosses into the ring domain through a synchroniser. Completion crosses back to the bus through a synchronised done handshake. The count crosses only once it is frozen.

Control writes are bit-masked: the upper halfword of the written word picks which lower-halfword bits change. Channels with more than four rings take the high bit of the ring index from a second, also masked, register.

Top module: `rom_channel`

## Requirements
- R1: A write to the control word (offset 0x00) changes lower bit n only if bit n+16 of the written data is 1. Every other control bit keeps its value, and the upper halfword always reads as 0.
- R2: With channel index C, start is control bit 4C, enable is bit 4C+1, and the low two ring-index bits sit at bits 4C+2 (LSB) and 4C+3. With more than four rings, bit 0 of the extension word (offset 0x14, written under mask bit 16) is ring-index bit 2.
- R3: Start has no effect while enable is 0: no window runs and the done bit stays 0.
- R4: After a window of W reference cycles, the count equals W × T_ref / T_ring of the selected ring, within ±2 edges.
- R5: Status word (offset 0x08) bit C is the done flag. The result word (offset 0x0C) holds the count once done is 1 and reads 0 before that.
- R6: A window length of zero (offset 0x04) gives done with a count of 0.
- R7: The count saturates at 2^CNT_W−1 and never wraps.
- R8: Clearing start clears done and the result. A following start measures afresh and does not accumulate.
- R9: A ring index at or above the number of rings counts nothing: done still sets and the result is 0.
- R10: After reset, the control, window, status, result and extension words all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side register clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| ref_clk | input | 1 | Reference clock that times the window |
| ring_clk | input | NUM_RINGS | Behavioural ring-oscillator clocks |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | 32 | Write data (upper halfword is the mask for control writes) |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Assertions check on every cycle that a control write with an empty mask leaves the control bits unchanged, and that done and the result drop once start or enable is gone. They also check that a zero window goes straight to done, that active and done are never high together, that the counter holds still once completion has been signalled, and that a saturated count stays at its maximum. Only the bench scenarios show that the count matches the ratio of the two clock frequencies for each ring, that the split ring index reaches the right oscillator, that out-of-range indices count nothing, and that a start without enable does nothing.

// File: rtl/rom_pkg.sv
package rom_pkg;

   localparam int unsigned OFF_CTRL = 32'h00;
   localparam int unsigned OFF_WIN  = 32'h04;
   localparam int unsigned OFF_STAT = 32'h08;
   localparam int unsigned OFF_RES  = 32'h0C;
   localparam int unsigned OFF_EXT  = 32'h14;

   // Apply a halfword write whose upper halfword enables each lower bit.
   function automatic logic [15:0] masked_update(input logic [15:0] cur,
                                                 input logic [31:0] wd);
      return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
   endfunction

endpackage

// File: rtl/rom_sync.sv
module rom_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rom_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/rom_ctrl_regs.sv
module rom_ctrl_regs
   import rom_pkg::*;
#(
   parameter int CH_IDX      = 1,
   parameter int NUM_RINGS   = 6,
   parameter int WIN_W       = 16,
   parameter int CNT_W       = 16,
   parameter int SEL_W       = 3,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              meas_go,
   output logic [WIN_W-1:0]  win_len,
   output logic [SEL_W-1:0]  ring_idx,
   input  logic              ring_done_async,
   input  logic [CNT_W-1:0]  ring_count
);

   localparam int START_B = CH_IDX * 4;
   localparam int EN_B    = START_B + 1;
   localparam int SEL_B   = START_B + 2;

   logic [15:0]      ctrl_q;
   logic [WIN_W-1:0] win_q;
   logic [CNT_W-1:0] result_q;
   logic             done_q;
   logic             armed_q;
   logic             done_s;
   logic             ext_rd;

   wire hit_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   wire hit_win  = bus_wr && (bus_addr == ADDR_W'(OFF_WIN));
   wire hit_ext  = bus_wr && (bus_addr == ADDR_W'(OFF_EXT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         win_q  <= '0;
      end else begin
         if (hit_ctrl) ctrl_q <= masked_update(ctrl_q, bus_wdata);
         if (hit_win)  win_q  <= bus_wdata[WIN_W-1:0];
      end
   end

   // Ring index assembly depends on how many rings the channel carries.
   generate
      if (NUM_RINGS > 4) begin : g_wide_sel
         logic ext_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         ext_q <= 1'b0;
            else if (hit_ext && bus_wdata[16])  ext_q <= bus_wdata[0];
         end
         assign ring_idx = {ext_q, ctrl_q[SEL_B+1:SEL_B]};
         assign ext_rd   = ext_q;
      end else if (NUM_RINGS > 1) begin : g_narrow_sel
         assign ring_idx = ctrl_q[SEL_B+1:SEL_B];
         assign ext_rd   = 1'b0;
      end else begin : g_single_ring
         assign ring_idx = '0;
         assign ext_rd   = 1'b0;
      end
   endgenerate

   assign meas_go = ctrl_q[START_B] & ctrl_q[EN_B];
   assign win_len = win_q;

   rom_sync #(.W(1), .STAGES(SYNC_STAGES)) u_done_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ring_done_async),
      .q     (done_s)
   );

   // Completion handshake: a done level seen only after a low is accepted,
   // so a stale flag from an earlier run cannot be mistaken for this one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         armed_q  <= 1'b0;
         result_q <= '0;
      end else if (!meas_go) begin
         done_q   <= 1'b0;
         armed_q  <= 1'b0;
         result_q <= '0;
      end else begin
         if (!done_s) armed_q <= 1'b1;
         if (armed_q && done_s && !done_q) begin
            done_q   <= 1'b1;
            result_q <= ring_count;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_CTRL))      bus_rdata[15:0]      = ctrl_q;
      else if (bus_addr == ADDR_W'(OFF_WIN))  bus_rdata[WIN_W-1:0] = win_q;
      else if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata[CH_IDX]    = done_q;
      else if (bus_addr == ADDR_W'(OFF_RES))  bus_rdata[CNT_W-1:0] = result_q;
      else if (bus_addr == ADDR_W'(OFF_EXT))  bus_rdata[0]         = ext_rd;
   end

   // R1: a control write with an empty mask changes nothing
   p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ctrl && bus_wdata[31:16] == 16'h0) |=> $stable(ctrl_q));

   // R3: done cannot survive without start and enable
   p_done_needs_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_go |=> !done_q);

   // R8: result is discarded once the run is stopped
   p_result_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_go |=> (result_q == '0));

endmodule

// File: rtl/rom_ref_window.sv
module rom_ref_window #(
   parameter int WIN_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             go_async,
   input  logic [WIN_W-1:0] win_len,
   output logic             win_active,
   output logic             win_done
);

   logic             go_s;
   logic             go_d;
   logic             active_q;
   logic             settle_q;
   logic             done_q;
   logic [WIN_W-1:0] rem_q;

   rom_sync #(.W(1), .STAGES(SYNC_STAGES)) u_go_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (go_async),
      .q     (go_s)
   );

   // active lasts exactly win_len reference cycles; one settle cycle then
   // separates its fall from the rise of done so the ring side sees them in order
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         go_d     <= 1'b0;
         active_q <= 1'b0;
         settle_q <= 1'b0;
         done_q   <= 1'b0;
         rem_q    <= '0;
      end else begin
         go_d <= go_s;
         if (!go_s) begin
            active_q <= 1'b0;
            settle_q <= 1'b0;
            done_q   <= 1'b0;
            rem_q    <= '0;
         end else if (!go_d) begin
            if (win_len == '0) begin
               done_q <= 1'b1;
            end else begin
               rem_q    <= win_len;
               active_q <= 1'b1;
            end
         end else if (active_q) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == WIN_W'(1)) begin
               active_q <= 1'b0;
               settle_q <= 1'b1;
            end
         end else if (settle_q) begin
            settle_q <= 1'b0;
            done_q   <= 1'b1;
         end
      end
   end

   assign win_active = active_q;
   assign win_done   = done_q;

   // R6: an empty window completes at once
   p_zero_window_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (go_s && !go_d && win_len == '0) |=> done_q);

   // R4: the window is closed whenever completion is reported
   p_active_done_excl_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !(active_q && done_q));

endmodule

// File: rtl/rom_ring_counter.sv
module rom_ring_counter #(
   parameter int NUM_RINGS   = 6,
   parameter int SEL_W       = 3,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 rst_n,
   input  logic [NUM_RINGS-1:0] ring_clk,
   input  logic [SEL_W-1:0]     ring_idx,
   input  logic                 go_async,
   input  logic                 active_async,
   input  logic                 done_async,
   output logic [CNT_W-1:0]     count,
   output logic                 ring_done
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [SEL_W:0]   RING_LIM = (SEL_W+1)'(NUM_RINGS);

   logic             meas_clk;
   logic             in_range;
   logic [2:0]       ctl_s;
   logic             go_s;
   logic             act_s;
   logic             done_s;
   logic [CNT_W-1:0] cnt_q;
   logic             ring_done_q;

   assign in_range = ({1'b0, ring_idx} < RING_LIM);

   // Behavioural ring multiplexer; an out-of-range index falls back to
   // ring 0 as a clock but counting is suppressed.
   always_comb begin
      meas_clk = ring_clk[0];
      for (int i = 0; i < NUM_RINGS; i++) begin
         if (in_range && ring_idx == SEL_W'(i)) meas_clk = ring_clk[i];
      end
   end

   rom_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ctl_sync (
      .clk   (meas_clk),
      .rst_n (rst_n),
      .d     ({go_async, active_async, done_async}),
      .q     (ctl_s)
   );

   assign go_s   = ctl_s[2];
   assign act_s  = ctl_s[1];
   assign done_s = ctl_s[0];

   always_ff @(posedge meas_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         ring_done_q <= 1'b0;
      end else begin
         ring_done_q <= go_s & done_s;
         if (!go_s)
            cnt_q <= '0;
         else if (act_s && in_range && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count     = cnt_q;
   assign ring_done = ring_done_q;

   // R7: a saturated count stays at the maximum while the run lasts
   p_sat_hold_r7: assert property (@(posedge meas_clk) disable iff (!rst_n)
      (go_s && $past(go_s) && $past(cnt_q) == CNT_MAX) |-> (cnt_q == CNT_MAX));

   // R4: once completion is signalled the count is frozen for the bus side
   p_frozen_after_done_r4: assert property (@(posedge meas_clk) disable iff (!rst_n)
      ring_done_q |=> (!go_s || $stable(cnt_q)));

endmodule

// File: rtl/rom_channel.sv
module rom_channel #(
   parameter int CH_IDX      = 1,
   parameter int NUM_RINGS   = 6,
   parameter int WIN_W       = 16,
   parameter int CNT_W       = 16,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ref_clk,
   input  logic [NUM_RINGS-1:0] ring_clk,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata
);

   localparam int SEL_W = (NUM_RINGS > 4) ? 3 : 2;

   generate
      if (CH_IDX < 0 || CH_IDX > 3) begin : g_bad_ch
         $error("CH_IDX must lie in 0..3 so its fields fit the halfword");
      end
      if (NUM_RINGS < 1 || NUM_RINGS > 8) begin : g_bad_rings
         $error("NUM_RINGS must lie in 1..8");
      end
      if (WIN_W < 1 || WIN_W > 32 || CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("WIN_W and CNT_W must lie in 1..32");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must reach the extension word");
      end
   endgenerate

   logic             meas_go;
   logic [WIN_W-1:0] win_len;
   logic [SEL_W-1:0] ring_idx;
   logic             win_active;
   logic             win_done;
   logic [CNT_W-1:0] ring_count;
   logic             ring_done;

   rom_ctrl_regs #(
      .CH_IDX      (CH_IDX),
      .NUM_RINGS   (NUM_RINGS),
      .WIN_W       (WIN_W),
      .CNT_W       (CNT_W),
      .SEL_W       (SEL_W),
      .ADDR_W      (ADDR_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_regs (
      .clk             (clk),
      .rst_n           (rst_n),
      .bus_addr        (bus_addr),
      .bus_wr          (bus_wr),
      .bus_wdata       (bus_wdata),
      .bus_rdata       (bus_rdata),
      .meas_go         (meas_go),
      .win_len         (win_len),
      .ring_idx        (ring_idx),
      .ring_done_async (ring_done),
      .ring_count      (ring_count)
   );

   rom_ref_window #(
      .WIN_W       (WIN_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_window (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .go_async   (meas_go),
      .win_len    (win_len),
      .win_active (win_active),
      .win_done   (win_done)
   );

   rom_ring_counter #(
      .NUM_RINGS   (NUM_RINGS),
      .SEL_W       (SEL_W),
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_counter (
      .rst_n        (rst_n),
      .ring_clk     (ring_clk),
      .ring_idx     (ring_idx),
      .go_async     (meas_go),
      .active_async (win_active),
      .done_async   (win_done),
      .count        (ring_count),
      .ring_done    (ring_done)
   );

endmodule

// File: tb/rom_channel_tb.sv
`timescale 1ns/1ps
module rom_channel_tb;

   localparam real CLK_PERIOD = 10.0;
   localparam real REF_PERIOD = 42.0;
   localparam int  CH         = 1;
   localparam int  NR         = 6;
   localparam int  CNT_W      = 8;
   localparam int  CNT_MAX    = (1 << CNT_W) - 1;
   localparam int  B_START    = CH * 4;
   localparam int  B_EN       = B_START + 1;
   localparam int  B_SEL      = B_START + 2;

   logic          clk = 1'b0;
   logic          ref_clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] ring_clk = '0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;

   int n_checks = 0;
   int n_fail   = 0;

   rom_channel #(.CH_IDX(CH), .NUM_RINGS(NR), .WIN_W(12), .CNT_W(CNT_W),
                 .ADDR_W(8), .SYNC_STAGES(2)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_clk   (ref_clk),
      .ring_clk  (ring_clk),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   function automatic real ring_period(int i);
      return 6.0 + 2.0 * i;
   endfunction

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(REF_PERIOD/2) ref_clk = ~ref_clk;
   for (genvar g = 0; g < NR; g++) begin : g_rings
      always #(ring_period(g)/2) ring_clk[g] = ~ring_clk[g];
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input int act, input real exp);
      real diff;
      n_checks++;
      diff = act - exp;
      if (diff < 0) diff = -diff;
      if (diff > 2.0) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0.1f", req, act, exp);
      end
   endtask

   task automatic wait_done(output bit ok);
      logic [31:0] s;
      ok = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         rd(8'h08, s);
         if (s[CH]) begin ok = 1'b1; break; end
      end
   endtask

   // Program in the required order and return the result; leaves start set.
   task automatic run(input int idx, input int w, output logic [31:0] res, output bit ok);
      wr(8'h00, (32'h1 << (16 + B_EN)) | (32'h1 << B_EN));
      wr(8'h00, (32'h3 << (16 + B_SEL)) | (32'(idx & 3) << B_SEL));
      wr(8'h14, 32'h0001_0000 | 32'((idx >> 2) & 1));
      wr(8'h04, 32'(w));
      wr(8'h00, (32'h1 << (16 + B_START)) | (32'h1 << B_START));
      wait_done(ok);
      rd(8'h0C, res);
   endtask

   task automatic stop();
      wr(8'h00, 32'h1 << (16 + B_START));
      wr(8'h00, 32'h1 << (16 + B_EN));
      repeat (20) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] v;
      bit ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10: reset state
      rd(8'h00, v); chk("R10 ctrl", v, 0);
      rd(8'h04, v); chk("R10 window", v, 0);
      rd(8'h08, v); chk("R10 status", v, 0);
      rd(8'h0C, v); chk("R10 result", v, 0);
      rd(8'h14, v); chk("R10 ext", v, 0);

      // R1: masked control writes
      wr(8'h00, 32'h0000_FFFF);
      rd(8'h00, v); chk("R1 empty mask", v, 0);
      wr(8'h00, (32'h1 << (16 + B_EN)) | 32'h0000_FFFF);
      rd(8'h00, v); chk("R1 single bit", v, 32'h1 << B_EN);
      wr(8'h00, (32'h1 << (16 + B_SEL + 1)) | 32'h0000_FFFF);
      rd(8'h00, v); chk("R1 second bit", v, (32'h1 << B_EN) | (32'h1 << (B_SEL + 1)));
      wr(8'h00, 32'hFFFF_0000);
      rd(8'h00, v); chk("R1 clear all", v, 0);
      wr(8'h14, 32'h0000_0001);
      rd(8'h14, v); chk("R2 ext needs mask", v, 0);

      // R3: start without enable
      wr(8'h04, 32'd10);
      wr(8'h00, (32'h1 << (16 + B_START)) | (32'h1 << B_START));
      repeat (300) @(negedge clk);
      rd(8'h08, v); chk("R3 no done without enable", v, 0);
      rd(8'h0C, v); chk("R3 no result without enable", v, 0);
      wr(8'h00, 32'h1 << (16 + B_START));

      // R5: result hidden before done
      wr(8'h00, (32'h1 << (16 + B_EN)) | (32'h1 << B_EN));
      wr(8'h04, 32'd50);
      wr(8'h00, (32'h1 << (16 + B_START)) | (32'h1 << B_START));
      rd(8'h08, v); chk("R5 done low early", v, 0);
      rd(8'h0C, v); chk("R5 result zero early", v, 0);
      stop();

      // R2 R4 R5: sweep every ring
      for (int i = 0; i < NR; i++) begin
         run(i, 20, v, ok);
         chk($sformatf("R5 done ring %0d", i), 32'(ok), 1);
         chk_near($sformatf("R4 R2 count ring %0d", i), int'(v), 20.0 * REF_PERIOD / ring_period(i));
         stop();
      end

      // R4: window length sweep on ring 2
      for (int w = 1; w <= 31; w += 6) begin
         run(2, w, v, ok);
         chk_near($sformatf("R4 window %0d", w), int'(v), w * REF_PERIOD / ring_period(2));
         stop();
      end

      // R9: out-of-range ring indices
      for (int i = NR; i < 8; i++) begin
         run(i, 20, v, ok);
         chk($sformatf("R9 done idx %0d", i), 32'(ok), 1);
         chk($sformatf("R9 count idx %0d", i), v, 0);
         stop();
      end

      // R6: zero window
      run(1, 0, v, ok);
      chk("R6 done", 32'(ok), 1);
      chk("R6 count", v, 0);
      stop();

      // R7: saturation
      run(0, 100, v, ok);
      chk("R7 saturated", v, CNT_MAX);
      stop();

      // R8: clearing start drops done and result; next run is fresh
      run(3, 10, v, ok);
      chk_near("R8 first run", int'(v), 10.0 * REF_PERIOD / ring_period(3));
      wr(8'h00, 32'h1 << (16 + B_START));
      repeat (3) @(negedge clk);
      rd(8'h08, v); chk("R8 done cleared", v, 0);
      rd(8'h0C, v); chk("R8 result cleared", v, 0);
      repeat (20) @(negedge clk);
      wr(8'h00, (32'h1 << (16 + B_START)) | (32'h1 << B_START));
      wait_done(ok);
      rd(8'h0C, v);
      chk_near("R8 fresh run", int'(v), 10.0 * REF_PERIOD / ring_period(3));
      stop();

      summary();
   end

endmodule